// File: doc/BRIEF.md
# ADC Start-Control Register with Trigger Logic

This block is the 8-bit control register that sits in front of an analog-to-digital converter. Software writes it to enable hardware triggering, to pick the converter clock rate and to start a conversion. The register also starts a conversion by itself when a hardware trigger arrives. The trigger comes either from an active-low external pin or from a one-cycle pulse from an internal timer. A separate select input chooses which of the two may start a conversion.

The start bit stays set while a conversion runs. A conversion-done pulse from the converter clears it. Every time the start bit rises, whatever set it, the block raises a single-cycle conversion-begin pulse. The five low bits are not implemented and always read as ones. A standby input returns the register to its reset value.

Top module: `adc_ctrl_reg`

## Requirements
- R1: After the asynchronous reset, and one cycle after `standby` is sampled high, `rdData` reads 0x1F and `startReq`, `clkSel` and `convBegin` are 0. `standby` takes priority over every other input.
- R2: `rdData[4:0]` always reads 5'b11111. Writing zeros to those positions has no effect on them.
- R3: A write (`wrEn` high) stores `wrData[7]` as trigger enable, `wrData[6]` as clock select and `wrData[5]` as start, visible on `rdData` in the next cycle. `clkSel` mirrors bit 6 and `startReq` mirrors bit 5.
- R4: While trigger enable (bit 7) is 0, neither the external pin nor the timer pulse sets the start bit.
- R5: With trigger enable set, `trigSrcTimer` = 0 and start = 0, a falling edge on `trigN` sets start. A low level held over at least two rising clock edges is detected, and start reads 1 after the third rising edge counted from the first edge that samples the low level.
- R6: A trigger that arrives while start is 1 is discarded. It is not remembered and does not act after start clears.
- R7: Only the source chosen by `trigSrcTimer` (1 = timer pulse, 0 = external pin) can set start. An event on the other source is ignored.
- R8: With trigger enable set, `trigSrcTimer` = 1 and start = 0, a one-cycle `timerTrig` pulse makes start read 1 in the next cycle.
- R9: `convDone` clears start in the next cycle. If `wrEn` is high in the same cycle, the written value of bit 5 wins.
- R10: `convBegin` is high for exactly one cycle, in the first cycle that start reads 1 after reading 0. This holds whether start was set by a write, the pin or the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| standby | input | 1 | Synchronous return to reset value |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| trigN | input | 1 | External trigger pin, active low, asynchronous |
| timerTrig | input | 1 | Internal timer trigger pulse |
| trigSrcTimer | input | 1 | Trigger source: 1 timer, 0 external pin |
| convDone | input | 1 | Conversion finished pulse |
| startReq | output | 1 | Conversion start bit |
| clkSel | output | 1 | Converter clock select bit |
| convBegin | output | 1 | One-cycle pulse when a conversion starts |

## Verification
Two pairs of functions can hit the start bit in the same cycle. The first pair is a software write and a conversion-done pulse. The bench drives both together and expects the written value to remain. The second pair is a detected external edge and a done pulse. The bench times the pin so that the synchronized edge appears in the same cycle as `convDone` while start is still 1. It then expects start to read 0, because the edge was discarded and not held for later.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int REG_W   = 8;
  localparam int TEN_BIT = 7;
  localparam int CKS_BIT = 6;
  localparam int STA_BIT = 5;
  localparam int RSV_W   = STA_BIT;

  typedef struct packed {
    logic wipe;     // return to reset value
    logic load;     // software write
    logic trigSet;  // accepted hardware trigger
    logic doneClr;  // conversion finished
  } adcrStrobe_t;
endpackage

// File: rtl/adcr_ctrl.sv
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        standby,
  input  logic        wrEn,
  input  logic        trigN,
  input  logic        timerTrig,
  input  logic        trigSrcTimer,
  input  logic        convDone,
  input  logic        trgEnQ,
  input  logic        startQ,
  output adcrStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   pinFall;
  logic                   srcEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= trigN;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[i] <= 1'b1;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[LAST];
  end

  always_comb begin
    pinFall  = prevQ & ~syncQ[LAST];
    srcEvent = trigSrcTimer ? timerTrig : pinFall;
    strobe.wipe    = standby;
    strobe.load    = wrEn;
    strobe.trigSet = trgEnQ & ~startQ & srcEvent;
    strobe.doneClr = convDone;
  end
endmodule

// File: rtl/adcr_datapath.sv
module adcr_datapath
  import adcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  adcrStrobe_t      strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             trgEnQ,
  output logic             clkSelQ,
  output logic             startQ,
  output logic             beginPulse
);
  logic startDly;
  logic unusedLow;

  assign unusedLow = ^wrData[RSV_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trgEnQ   <= 1'b0;
      clkSelQ  <= 1'b0;
      startQ   <= 1'b0;
      startDly <= 1'b0;
    end else if (strobe.wipe) begin
      trgEnQ   <= 1'b0;
      clkSelQ  <= 1'b0;
      startQ   <= 1'b0;
      startDly <= 1'b0;
    end else begin
      startDly <= startQ;
      if (strobe.load) begin
        trgEnQ  <= wrData[TEN_BIT];
        clkSelQ <= wrData[CKS_BIT];
        startQ  <= wrData[STA_BIT];
      end else if (strobe.trigSet) begin
        startQ  <= 1'b1;
      end else if (strobe.doneClr) begin
        startQ  <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData          = '1;
    rdData[TEN_BIT] = trgEnQ;
    rdData[CKS_BIT] = clkSelQ;
    rdData[STA_BIT] = startQ;
    beginPulse      = startQ & ~startDly;
  end
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       standby,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       trigN,
  input  logic       timerTrig,
  input  logic       trigSrcTimer,
  input  logic       convDone,
  output logic       startReq,
  output logic       clkSel,
  output logic       convBegin
);
  adcrStrobe_t strobe;
  logic        trgEnQ;

  adcr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn),
    .trigN(trigN), .timerTrig(timerTrig), .trigSrcTimer(trigSrcTimer),
    .convDone(convDone), .trgEnQ(trgEnQ), .startQ(startReq),
    .strobe(strobe)
  );

  adcr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .trgEnQ(trgEnQ), .clkSelQ(clkSel),
    .startQ(startReq), .beginPulse(convBegin)
  );
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       standby,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       convDone,
  input logic [7:0] rdData,
  input logic       startReq,
  input logic       convBegin
);
  assert_wipe_R1: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (rdData == 8'h1F));

  assert_reserved_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[4:0] == 5'h1F);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !standby) |=> (startReq == $past(wrData[5])));

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && startReq && !wrEn && !standby) |=> !startReq);

  assert_no_trig_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[7] && !startReq && !wrEn) |=> !startReq);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !wrEn && !convDone && !standby) |=> startReq);

  assert_begin_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    convBegin |-> startReq);

  assert_begin_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    convBegin |=> !convBegin);
endmodule

bind adc_ctrl_reg adcr_chk u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .wrData(wrData),
  .convDone(convDone), .rdData(rdData), .startReq(startReq),
  .convBegin(convBegin)
);

// File: tb/sim_adc_ctrl_reg.sv
module sim_adc_ctrl_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standby = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       trigN = 1'b1;
  logic       timerTrig = 1'b0;
  logic       trigSrcTimer = 1'b0;
  logic       convDone = 1'b0;
  logic       startReq, clkSel, convBegin;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_ctrl_reg u0 (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .trigN(trigN), .timerTrig(timerTrig),
    .trigSrcTimer(trigSrcTimer), .convDone(convDone), .startReq(startReq),
    .clkSel(clkSel), .convBegin(convBegin)
  );

  // {wrEn, wrData, timerTrig, trigSrcTimer, convDone, expRd, expBegin}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0}, // R2 zeros to reserved
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1}, // R3 R10 write start
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0}, // R10 single pulse
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hDF, 1'b0}, // R9 done clears
    {1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 8'h5F, 1'b0}, // R3 clock select only
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h5F, 1'b0}, // R4 timer while disabled
    {1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h9F, 1'b0}, // R3 enable
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h9F, 1'b0}, // R7 timer unselected
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hBF, 1'b1}, // R8 timer starts
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hBF, 1'b0}, // R6 timer while busy
    {1'b1, 8'hA0, 1'b0, 1'b0, 1'b1, 8'hBF, 1'b0}, // R9 write beats done
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h9F, 1'b0}, // R9 done clears
    {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 8'h3F, 1'b1}, // R10 begin on write
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0}  // R3 software clear
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrEn = 1'b0; timerTrig = 1'b0; convDone = 1'b0; standby = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1 reset rd", rdData, 8'h1F);
    check("R1 reset outs", {5'b0, startReq, clkSel, convBegin}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    step();

    for (int i = 0; i < NV; i++) begin
      {wrEn, wrData, timerTrig, trigSrcTimer, convDone} = VEC[i][20:9];
      step();
      check($sformatf("vec%0d rdData", i), rdData, VEC[i][8:1]);
      check($sformatf("vec%0d convBegin", i), {7'b0, convBegin}, {7'b0, VEC[i][0]});
    end
    idle();

    // R5: external edge with enable, pin source
    wrEn = 1'b1; wrData = 8'h80; trigSrcTimer = 1'b0; step(); idle();
    trigN = 1'b0;
    step();
    step();
    check("R5 not yet", {7'b0, startReq}, 8'h00);
    step();
    check("R5 edge sets start", {7'b0, startReq}, 8'h01);
    check("R10 begin on edge", {7'b0, convBegin}, 8'h01);
    step();
    check("R10 begin ends", {7'b0, convBegin}, 8'h00);
    trigN = 1'b1;
    step(); step();

    // R6: edge and done in the same cycle; edge dropped
    trigN = 1'b0;
    step(); step();
    convDone = 1'b1; step(); idle();
    check("R6 edge dropped with done", {7'b0, startReq}, 8'h00);
    step(); step();
    check("R6 not remembered", {7'b0, startReq}, 8'h00);
    trigN = 1'b1; step(); step();

    // R7: pin edge with timer selected
    trigSrcTimer = 1'b1;
    trigN = 1'b0; step(); step(); step(); step();
    check("R7 pin unselected", {7'b0, startReq}, 8'h00);
    trigN = 1'b1; trigSrcTimer = 1'b0; step(); step();

    // R4: pin edge with enable cleared
    wrEn = 1'b1; wrData = 8'h00; step(); idle();
    trigN = 1'b0; step(); step(); step(); step();
    check("R4 pin while disabled", rdData, 8'h1F);
    trigN = 1'b1; step(); step();

    // R1: standby beats a write
    wrEn = 1'b1; wrData = 8'hE0; step(); idle();
    check("R3 full write", rdData, 8'hFF);
    standby = 1'b1; wrEn = 1'b1; wrData = 8'hE0; step(); idle();
    check("R1 standby rd", rdData, 8'h1F);
    check("R1 standby outs", {5'b0, startReq, clkSel, convBegin}, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule